// File: doc/BRIEF.md
# Extended Parallel Port Control Window with Test FIFO

This block is the extended register window of a PC-style parallel port. A host reaches it through a synchronous byte bus with a 3-bit offset. The window holds a mode/status control register, a general configuration byte and a shared data location at offset 0. The mode field decides what the data location does. In the FIFO-test mode it is a small byte FIFO that software can fill and drain to check the queue. In every other mode it is an ordinary byte register.

The control register reports the FIFO fill state in its two low bits. A control write that selects a mode other than the current one empties the FIFO. Transfers to the port pins are not part of this block. Only the mode storage and the test FIFO behave.

Reads are combinational: `rdata` shows the addressed location during the cycle in which `rd_en` is high. Any pop or write side effect takes place at the next rising clock edge.

Top module: `ecp_ext_ctrl`

## Requirements
- R1: Only `addr` selects the location. 0 is the data location, 1 is the configuration byte and 2 is the control register. Offsets 3 to 7 read 0xFF and ignore writes.
- R2: Control register bits 7:5 hold the mode: 0 compatible, 1 byte, 2 parallel FIFO, 3 extended FIFO, 4 enhanced, 5 reserved, 6 FIFO test, 7 configuration. A write replaces the whole field. Bits 4:2 read 0. Bits 1:0 are read-only status and ignore written values.
- R3: After reset the mode is 0, the control register reads 0x01, and the configuration byte and plain data register read 0x00.
- R4: In any mode other than 6, offset 0 is a plain byte register that returns the last value written to it.
- R5: In mode 6, a write to offset 0 pushes a byte. Status bits 1:0 read 00 while the FIFO holds data with space left, and 10 once all DEPTH (default 2) slots hold data.
- R6: In mode 6, a read of offset 0 returns the oldest byte and pops it. Order is first-in first-out across pointer wrap. Status reads 01 once the FIFO is drained.
- R7: A push while the FIFO is full is dropped and leaves its contents and status unchanged.
- R8: A pop while the FIFO is empty returns the most recently popped byte (0x00 if none since reset) and moves nothing.
- R9: A control write whose mode differs from the current mode empties the FIFO (status 01). A control write with the same mode leaves the FIFO contents intact.
- R10: If `wr_en` and `rd_en` are high in the same cycle, only the write takes effect. `rdata` still shows the addressed value, with no pop.
- R11: The configuration byte is a plain read/write register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle (pops in FIFO-test mode) |
| addr | input | 3 | Register offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed offset |

## Verification
The hardest states to reach are the ones where the FIFO state interacts with a mode change or with a drop. Examples are a flush that hits a partly filled FIFO, a pop from an empty FIFO right after a flush, and a push that meets a full FIFO after the pointers have wrapped. Directed sequences set each of these up first. Seeded random traffic then follows, with control writes biased toward the FIFO-test mode and toward re-writing the same mode. Under that traffic the FIFO repeatedly fills, wraps, empties and flushes. A queue model in the bench checks every read.

// File: rtl/ecp_ext_pkg.sv
package ecp_ext_pkg;
    typedef enum logic [2:0] {
        MODE_COMPAT  = 3'd0,
        MODE_BYTE    = 3'd1,
        MODE_PFIFO   = 3'd2,
        MODE_XFIFO   = 3'd3,
        MODE_ENH     = 3'd4,
        MODE_RSVD    = 3'd5,
        MODE_FTEST   = 3'd6,
        MODE_CONFIG  = 3'd7
    } ecp_mode_e;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_CFGB = 3'd1;
    localparam logic [2:0] OFS_CTRL = 3'd2;
endpackage

// File: rtl/ecp_test_fifo.sv
module ecp_test_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              flush,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wptr;
        logic [PTR_W-1:0]             rptr;
        logic [CNT_W-1:0]             cnt;
        logic [DATA_W-1:0]            last;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wptr = '0;
            st_d.rptr = '0;
            st_d.cnt  = '0;
        end else if (push && !full) begin
            st_d.mem[st_q.wptr] = wdata;
            st_d.wptr = (st_q.wptr == LAST_SLOT) ? '0 : st_q.wptr + 1'b1;
            st_d.cnt  = st_q.cnt + 1'b1;
        end else if (pop && !empty) begin
            st_d.last = st_q.mem[st_q.rptr];
            st_d.rptr = (st_q.rptr == LAST_SLOT) ? '0 : st_q.rptr + 1'b1;
            st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign rdata = empty ? st_q.last : st_q.mem[st_q.rptr];

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !flush) |=> (full && $stable(st_q.wptr)));
    assert_empty_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> (empty && $stable(rdata)));
    assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/ecp_ctrl_regs.sv
module ecp_ctrl_regs
    import ecp_ext_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output ecp_mode_e         mode,
    output logic [DATA_W-1:0] cfgb,
    output logic [DATA_W-1:0] plain,
    output logic              flush
);
    localparam int MODE_LSB = DATA_W - 3;

    typedef struct packed {
        ecp_mode_e         mode;
        logic [DATA_W-1:0] cfgb;
        logic [DATA_W-1:0] plain;
    } regs_st_t;

    regs_st_t st_d, st_q;
    ecp_mode_e new_mode;

    always_comb begin
        new_mode = ecp_mode_e'(wdata[DATA_W-1:MODE_LSB]);
        st_d  = st_q;
        flush = 1'b0;
        if (wr_en) begin
            unique case (addr)
                OFS_DATA: if (st_q.mode != MODE_FTEST) st_d.plain = wdata;
                OFS_CFGB: st_d.cfgb = wdata;
                OFS_CTRL: begin
                    flush     = (new_mode != st_q.mode);
                    st_d.mode = new_mode;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_COMPAT, cfgb: '0, plain: '0};
        else        st_q <= st_d;
    end

    assign mode  = st_q.mode;
    assign cfgb  = st_q.cfgb;
    assign plain = st_q.plain;

    assert_mode_replace_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CTRL) |=> (mode == $past(wdata[DATA_W-1:MODE_LSB])));
    assert_cfgb_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CFGB) |=> (cfgb == $past(wdata)));
    assert_hi_ofs_inert_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > OFS_CTRL) |=> ($stable(mode) && $stable(cfgb) && $stable(plain)));
endmodule

// File: rtl/ecp_ext_ctrl.sv
module ecp_ext_ctrl
    import ecp_ext_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - 5;

    ecp_mode_e         mode;
    logic [DATA_W-1:0] cfgb, plain, fifo_rdata;
    logic              flush, fifo_empty, fifo_full;
    logic              rd_eff, is_ftest, push, pop;

    assign rd_eff   = rd_en && !wr_en;
    assign is_ftest = (mode == MODE_FTEST);
    assign push     = wr_en  && (addr == OFS_DATA) && is_ftest;
    assign pop      = rd_eff && (addr == OFS_DATA) && is_ftest;

    ecp_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .mode(mode), .cfgb(cfgb), .plain(plain), .flush(flush)
    );

    ecp_test_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
        .wdata(wdata), .rdata(fifo_rdata), .empty(fifo_empty), .full(fifo_full)
    );

    always_comb begin
        unique case (addr)
            OFS_DATA: rdata = is_ftest ? fifo_rdata : plain;
            OFS_CFGB: rdata = cfgb;
            OFS_CTRL: rdata = {mode, {PAD_W{1'b0}}, fifo_full, fifo_empty};
            default:  rdata = '1;
        endcase
    end

    assert_status_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_full, fifo_empty}));
    assert_both_no_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && addr == OFS_DATA && is_ftest && !fifo_full) |=> !fifo_empty);
endmodule

// File: tb/ecp_ext_ctrl_test.sv
module ecp_ext_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;

    int n_cmp = 0;
    int n_bad = 0;

    logic [2:0] m_mode = 3'd0;
    logic [7:0] m_cfgb = 8'd0;
    logic [7:0] m_plain = 8'd0;
    logic [7:0] m_last = 8'd0;
    logic [7:0] m_q[$];
    localparam int DEPTH = 2;

    ecp_ext_ctrl uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                      .addr(addr), .wdata(wdata), .rdata(rdata));

    always #10 clk = ~clk;

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: exp_read = (m_mode == 3'd6) ? ((m_q.size() > 0) ? m_q[0] : m_last) : m_plain;
            3'd1: exp_read = m_cfgb;
            3'd2: exp_read = {m_mode, 3'b000, m_q.size() == DEPTH, m_q.size() == 0};
            default: exp_read = 8'hFF;
        endcase
    endfunction

    task automatic model_write(input logic [2:0] a, input logic [7:0] d);
        case (a)
            3'd0: if (m_mode == 3'd6) begin
                      if (m_q.size() < DEPTH) m_q.push_back(d);
                  end else m_plain = d;
            3'd1: m_cfgb = d;
            3'd2: begin
                      if (d[7:5] != m_mode) m_q.delete();
                      m_mode = d[7:5];
                  end
            default: ;
        endcase
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_rd(input logic [2:0] a, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #2 check(req, rdata, exp_read(a));
        @(posedge clk); #1;
        rd_en = 1'b0;
        if (a == 3'd0 && m_mode == 3'd6 && m_q.size() > 0) m_last = m_q.pop_front();
    endtask

    task automatic bus_both(input logic [2:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        #2 check(req, rdata, exp_read(a));
        @(posedge clk); #1;
        rd_en = 1'b0; wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic finish_up;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        // R3 reset state
        bus_rd(3'd2, "R3 ctrl");
        check("R3 ctrl literal", rdata, 8'h01);
        bus_rd(3'd1, "R3 cfgb");
        bus_rd(3'd0, "R3 data");
        // R1 high offsets
        for (int i = 3; i < 8; i++) bus_wr(3'(i), 8'h00);
        for (int i = 3; i < 8; i++) bus_rd(3'(i), "R1 hi ofs");
        bus_rd(3'd2, "R1 ctrl untouched");
        // R11 configuration byte
        bus_wr(3'd1, 8'hA5); bus_rd(3'd1, "R11 cfgb");
        // R4 plain register
        bus_wr(3'd0, 8'h3C); bus_rd(3'd0, "R4 plain mode0");
        bus_wr(3'd2, 8'h20); bus_rd(3'd0, "R4 plain kept");
        bus_wr(3'd0, 8'h5A); bus_rd(3'd0, "R4 plain mode1");
        // R2 field replace, status read-only
        bus_wr(3'd2, 8'hDF); bus_rd(3'd2, "R2 ctrl 0xC1");
        bus_wr(3'd2, 8'h3F); bus_rd(3'd2, "R2 replace");
        bus_wr(3'd2, 8'hC0);
        // R5 push and status
        bus_wr(3'd0, 8'h11); bus_rd(3'd2, "R5 some data");
        bus_wr(3'd0, 8'h22); bus_rd(3'd2, "R5 full");
        // R7 drop when full
        bus_wr(3'd0, 8'h33); bus_rd(3'd2, "R7 still full");
        bus_rd(3'd0, "R6 pop first"); bus_rd(3'd0, "R6 pop second");
        bus_rd(3'd2, "R6 empty");
        // R8 pop when empty
        bus_rd(3'd0, "R8 empty pop"); bus_rd(3'd0, "R8 empty pop again");
        bus_rd(3'd2, "R8 still empty");
        // R6 wrap
        bus_wr(3'd0, 8'h44); bus_wr(3'd0, 8'h55); bus_rd(3'd0, "R6 wrap a");
        bus_wr(3'd0, 8'h66); bus_rd(3'd2, "R7 full after wrap");
        bus_wr(3'd0, 8'h99);
        bus_rd(3'd0, "R6 wrap b"); bus_rd(3'd0, "R6 wrap c");
        // R9 same mode keeps, new mode flushes
        bus_wr(3'd0, 8'h77); bus_wr(3'd2, 8'hC0); bus_rd(3'd2, "R9 same mode");
        bus_rd(3'd0, "R9 kept byte");
        bus_wr(3'd0, 8'h88); bus_wr(3'd2, 8'h00); bus_rd(3'd2, "R9 flushed");
        bus_wr(3'd2, 8'hC0); bus_rd(3'd2, "R9 empty in test");
        bus_rd(3'd0, "R9 R8 last byte");
        // R10 simultaneous
        bus_both(3'd0, 8'hAB, "R10 no pop view");
        bus_rd(3'd2, "R10 write took");
        bus_rd(3'd0, "R10 pushed byte");
        // random traffic
        void'($urandom(32'h00C0FFEE));
        for (int k = 0; k < 600; k++) begin
            int op;
            logic [2:0] a;
            logic [7:0] d;
            op = $urandom_range(0, 11);
            a  = ($urandom_range(0, 5) == 0) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(0, 2));
            d  = 8'($urandom);
            if (op < 5) bus_rd(a, (a == 3'd0) ? "R6 rand rd" : "R11 rand rd");
            else if (op < 9) bus_wr((a == 3'd2) ? 3'd0 : a, d);
            else if (op < 11) bus_wr(3'd2, {($urandom_range(0, 2) != 0) ? 3'd6 : 3'($urandom_range(0, 7)), d[4:0]});
            else bus_both(a, d, "R10 rand both");
        end
        finish_up();
    end
endmodule